// File: doc/BRIEF.md
# Power-On and Warm Reset Sequencer with Configuration Capture

This block produces the system reset for one bus agent. A power-on reset is held until power-good and clock-valid are both true, and then for a programmed minimum number of cycles. A warm reset, requested at run time, holds reset for the same minimum. The default minimum, `HOLD_CYCLES`, is 50000 cycles, which is one millisecond at 50 MHz.

While reset is active, the agent's bus output enables are forced inactive within two clock edges. On the clock edge where reset releases, the block samples a vector of configuration pins into a register. That register then keeps its value until the next release. One cycle-wide start-execution pulse follows the release, unless the captured configuration holds the agent's outputs tristated. Cache invalidation and fetching the first instruction are the job of other logic.

Top module: `rst_seq_cfg`

## Requirements
- R1: While rst_ni is low: sys_rst_o=1, bus_oe_o=0, start_o=0 and cfg_q_o=CFG_RST (default 0).
- R2: Reset releases on the HOLD_CYCLES-th rising edge after the cycle in which pwr_good_i and clk_valid_i are both first high. Any cycle in which either is low restarts the count.
- R3: When pwr_good_i is low at a rising edge, sys_rst_o is 1 after that edge and the hold count restarts.
- R4: When warm_req_i is high at a rising edge while out of reset, sys_rst_o is 1 after that edge. Release then follows HOLD_CYCLES edges later.
- R5: A warm_req_i seen during reset restarts the count. Release comes HOLD_CYCLES edges after the last edge at which the request was seen.
- R6: bus_oe_o is all zeros from the second rising edge after a reset trigger, and it stays zero while sys_rst_o is 1.
- R7: cfg_q_o takes the value of cfg_pins_i sampled on the release edge, meaning the pins driven in the last reset cycle. At every other edge it is unchanged.
- R8: When bit TRI_BIT (default 0) of the captured configuration is 0, start_o is high for exactly one cycle: the first cycle with sys_rst_o low. When that bit is 1, no pulse occurs and bus_oe_o stays zero.
- R9: Out of reset with the tristate bit 0, bus_oe_o equals oe_req_i delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous chip-level reset, active low |
| pwr_good_i | input | 1 | Supplies within specification |
| clk_valid_i | input | 1 | Bus clock stable |
| warm_req_i | input | 1 | Run-time warm reset request |
| cfg_pins_i | input | CFG_W | Configuration pins sampled at release |
| oe_req_i | input | OE_W | Output enables requested by agent logic |
| sys_rst_o | output | 1 | System reset, active high |
| bus_oe_o | output | OE_W | Gated bus output enables |
| cfg_q_o | output | CFG_W | Captured configuration |
| start_o | output | 1 | One-cycle start-execution pulse |

## Verification
A hold counter that is off by one moves the falling edge of sys_rst_o by one cycle. The same fault moves the start_o pulse and the captured cfg_q_o value with it, so the error shows at release. A capture enable on the wrong edge leaves cfg_q_o holding a neighbouring pin value, because the bench changes the pins every cycle. A gate that is slow or missing leaves bus_oe_o nonzero at the second edge after a trigger. A missing restart on power-good loss or on a repeated warm request shortens the measured hold.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HOLD = 1'b1
  } seq_state_e;
endpackage

// File: rtl/rst_hold_ctr.sv
module rst_hold_ctr
  import rst_seq_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic clk_valid_i,
  input  logic warm_req_i,
  output logic in_rst_o,
  output logic release_o
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  seq_state_e state_q;
  logic [CNT_W-1:0] cnt_q;
  logic qualify;

  // counting needs clean power, a stable clock and no pending warm request
  assign qualify   = pwr_good_i & clk_valid_i & ~warm_req_i;
  assign in_rst_o  = (state_q == ST_HOLD);
  assign release_o = in_rst_o & qualify & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_HOLD: begin
          if (!qualify) begin
            cnt_q <= '0;
          end else if (cnt_q == LAST) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          cnt_q <= '0;
          if (!pwr_good_i || warm_req_i) state_q <= ST_HOLD;
        end
      endcase
    end
  end
endmodule

// File: rtl/cfg_latch.sv
module cfg_latch #(
  parameter int unsigned CFG_W   = 8,
  parameter logic [CFG_W-1:0] CFG_RST = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CFG_W-1:0] d_i,
  output logic [CFG_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= CFG_RST;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/oe_gate.sv
module oe_gate #(
  parameter int unsigned OE_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_rst_i,
  input  logic            tri_i,
  input  logic [OE_W-1:0] req_i,
  output logic [OE_W-1:0] oe_o
);
  logic kill;
  assign kill = in_rst_i | tri_i;

  for (genvar g = 0; g < OE_W; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) oe_o[g] <= 1'b0;
      else         oe_o[g] <= req_i[g] & ~kill;
    end
  end
endmodule

// File: rtl/rst_seq_cfg.sv
module rst_seq_cfg #(
  parameter int unsigned HOLD_CYCLES = 50000,
  parameter int unsigned CFG_W       = 8,
  parameter int unsigned OE_W        = 4,
  parameter int unsigned TRI_BIT     = 0,
  parameter logic [CFG_W-1:0] CFG_RST = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_good_i,
  input  logic             clk_valid_i,
  input  logic             warm_req_i,
  input  logic [CFG_W-1:0] cfg_pins_i,
  input  logic [OE_W-1:0]  oe_req_i,
  output logic             sys_rst_o,
  output logic [OE_W-1:0]  bus_oe_o,
  output logic [CFG_W-1:0] cfg_q_o,
  output logic             start_o
);
  logic in_rst, release_pulse, start_q;

  rst_hold_ctr #(.HOLD_CYCLES(HOLD_CYCLES)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_good_i (pwr_good_i),
    .clk_valid_i(clk_valid_i),
    .warm_req_i (warm_req_i),
    .in_rst_o   (in_rst),
    .release_o  (release_pulse)
  );

  cfg_latch #(.CFG_W(CFG_W), .CFG_RST(CFG_RST)) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(release_pulse),
    .d_i   (cfg_pins_i),
    .q_o   (cfg_q_o)
  );

  oe_gate #(.OE_W(OE_W)) u_oe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .in_rst_i(in_rst),
    .tri_i   (cfg_q_o[TRI_BIT]),
    .req_i   (oe_req_i),
    .oe_o    (bus_oe_o)
  );

  // pulse decided from the pins being captured on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b0;
    else         start_q <= release_pulse & ~cfg_pins_i[TRI_BIT];
  end

  assign sys_rst_o = in_rst;
  assign start_o   = start_q;
endmodule

// File: rtl/rst_seq_cfg_chk.sv
module rst_seq_cfg_chk #(
  parameter int unsigned CFG_W   = 8,
  parameter int unsigned OE_W    = 4,
  parameter int unsigned TRI_BIT = 0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pwr_good_i,
  input logic             clk_valid_i,
  input logic             warm_req_i,
  input logic             sys_rst_o,
  input logic [OE_W-1:0]  bus_oe_o,
  input logic [CFG_W-1:0] cfg_q_o,
  input logic             start_o
);
  // R3
  pgood_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> sys_rst_o);
  // R4
  warm_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_req_i |=> sys_rst_o);
  // R2
  release_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> $past(pwr_good_i && clk_valid_i && !warm_req_i));
  // R6
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> (bus_oe_o == '0));
  // R7
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(sys_rst_o) |-> $stable(cfg_q_o));
  // R8
  start_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> ($past(sys_rst_o) && !sys_rst_o && !cfg_q_o[TRI_BIT]));
  // R8
  start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
endmodule

bind rst_seq_cfg rst_seq_cfg_chk #(.CFG_W(CFG_W), .OE_W(OE_W), .TRI_BIT(TRI_BIT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwr_good_i (pwr_good_i),
  .clk_valid_i(clk_valid_i),
  .warm_req_i (warm_req_i),
  .sys_rst_o  (sys_rst_o),
  .bus_oe_o   (bus_oe_o),
  .cfg_q_o    (cfg_q_o),
  .start_o    (start_o)
);

// File: tb/rst_seq_cfg_bench.sv
`timescale 1ns/1ps
module rst_seq_cfg_bench;
  localparam int HOLD  = 12;
  localparam int CFG_W = 6;
  localparam int OE_W  = 4;

  logic clk = 1'b0;
  logic rst_n, pgood, cvalid, warm;
  logic [CFG_W-1:0] cfg_pins;
  logic [OE_W-1:0] oe_req, oe;
  logic sys_rst, start;
  logic [CFG_W-1:0] cfg_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rst_seq_cfg #(.HOLD_CYCLES(HOLD), .CFG_W(CFG_W), .OE_W(OE_W)) u_rst_seq_cfg (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pgood), .clk_valid_i(cvalid),
    .warm_req_i(warm), .cfg_pins_i(cfg_pins), .oe_req_i(oe_req),
    .sys_rst_o(sys_rst), .bus_oe_o(oe), .cfg_q_o(cfg_q), .start_o(start)
  );

  localparam int NV = 8;
  localparam logic [OE_W-1:0] OE_VEC [NV] = '{4'h0, 4'hF, 4'h5, 4'hA, 4'h1, 4'h8, 4'h3, 4'hC};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [CFG_W-1:0] pat(input int j, input logic tri_b);
    return CFG_W'((j * 2) | int'(tri_b));
  endfunction

  // count edges from now to release, changing pins every cycle
  task automatic measure(input logic tri_b, output int n, output logic [CFG_W-1:0] want);
    n = 0;
    cfg_pins = pat(1, tri_b);
    want = '0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      n++;
      if (!sys_rst) begin
        want = pat(n, tri_b);
        break;
      end
      cfg_pins = pat(n + 1, tri_b);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [CFG_W-1:0] want;
    rst_n = 0; pgood = 0; cvalid = 0; warm = 0; cfg_pins = '0; oe_req = 4'hF;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 sys_rst", sys_rst, 1);
    chk("R1 oe", oe, 0);
    chk("R1 start", start, 0);
    chk("R1 cfg", cfg_q, 0);
    rst_n = 1;
    pgood = 1;
    repeat (4) @(negedge clk);
    cvalid = 1;
    repeat (5) @(negedge clk);
    cvalid = 0;
    repeat (2) @(negedge clk);
    // R2 no release with the clock invalid
    chk("R2 held", sys_rst, 1);
    chk("R6 oe in reset", oe, 0);
    cvalid = 1;
    measure(1'b0, n, want);
    // R2 count restarted after clk_valid dropout
    chk("R2 hold", n, HOLD);
    // R7
    chk("R7 capture", cfg_q, want);
    // R8
    chk("R8 start", start, 1);
    chk("R6 oe at release", oe, 0);
    cfg_pins = 6'h3E;
    @(negedge clk);
    chk("R8 width", start, 0);
    chk("R7 hold", cfg_q, want);

    // R9 table walk
    for (int i = 0; i < NV; i++) begin
      oe_req = OE_VEC[i];
      @(negedge clk);
      chk("R9 pass", oe, OE_VEC[i]);
    end

    // R4 / R6 warm reset, then R5 re-request
    oe_req = 4'hF;
    @(negedge clk);
    warm = 1;
    @(negedge clk);
    warm = 0;
    chk("R4 assert", sys_rst, 1);
    @(negedge clk);
    chk("R6 two edges", oe, 0);
    repeat (3) @(negedge clk);
    warm = 1;
    @(negedge clk);
    warm = 0;
    measure(1'b1, n, want);
    // R5: one request edge plus a full hold
    chk("R5 hold", n + 1, HOLD + 1);
    chk("R7 capture tri", cfg_q, want);
    chk("R8 no start", start, 0);
    repeat (3) begin
      @(negedge clk);
      chk("R8 tri oe", oe, 0);
      chk("R8 no start", start, 0);
    end

    // R3 power loss while running
    pgood = 0;
    @(negedge clk);
    chk("R3 assert", sys_rst, 1);
    repeat (3) @(negedge clk);
    chk("R3 held", sys_rst, 1);
    pgood = 1;
    measure(1'b0, n, want);
    chk("R3 hold", n, HOLD);
    chk("R8 start", start, 1);
    @(negedge clk);
    chk("R9 oe after release", oe, 4'hF);
    chk("R8 width", start, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule